// File: doc/BRIEF.md
# Shadowed Video Write Snooper

This block sits beside a host expansion bus and picks out the processor writes that land in the host's video display areas, so that a card can keep a copy of the screen in its own memory. It watches the 1 MHz phase clock, a quadrature clock, an active-low slow-side select, a one-bit bank indicator, the read/write line, the 16-bit address and the 8-bit data bus. All of these are sampled on the card's fast system clock. After an equal-depth synchronizer, edges on the two bus clocks are found by comparing the signal with its value one cycle earlier.

The bank indicator is driven onto the bus only for a short window during the phase-low (address) half of a bus cycle. The block copies it when the quadrature clock falls inside that half. The block does not look at address bits or memory-mapping switches to learn the bank: the bank it reports is exactly the captured bit. During the following phase-high (data) half, the block keeps overwriting its copy of the select, read/write, address and data lines. What remains at the phase fall is the last value seen before the fall. At that fall the access is qualified and its address is decoded against two windows: text page 1 at 0x0400–0x07FF and hi-res page 1 at 0x2000–0x3FFF. A write that hits a window is offered on a valid/ready output as bank, offset and data.

Back-pressure rules: an item stays on the output, unchanged, until it is taken in a cycle with `snp_valid` and `snp_ready` both high. The output holds one item. If a new qualifying write completes while an item is waiting and `snp_ready` is low, the new write is discarded. If the waiting item is taken in the same cycle that a new item is loaded, the new item replaces it with no gap. With `snp_ready` tied high, each capture appears as a single-cycle strobe.

Top module: `shadow_snoop`

## Requirements
- R1: While `rst_n` is low, `snp_valid` is 0.
- R2: The reported bank equals the value of `bank_bit` when `quad_clk` falls while `phase_clk` is low. Values of `bank_bit` at other times are ignored, including at `quad_clk` falls while `phase_clk` is high.
- R3: Only a write cycle can produce an item: `rd_wr_n` = 0 and `slow_sel_n` = 0. A cycle with `rd_wr_n` = 1 (read) or `slow_sel_n` = 1 (fast side) produces nothing.
- R4: An item is produced only for addresses from 0x0400 to 0x07FF or from 0x2000 to 0x3FFF, both ends inclusive. The addresses 0x03FF, 0x0800, 0x1FFF and 0x4000 produce nothing.
- R5: The item carries the full 16-bit address as `snp_offset` and the data byte present on `data_bus` at the last sample before `phase_clk` falls. Earlier data in the same high half has no effect.
- R6: An item first appears while `phase_clk` is low, the cycle after the synchronized phase fall. With `snp_ready` high it stays valid for exactly one clock.
- R7: While `snp_valid` is 1 and `snp_ready` is 0, the bank, offset and data hold stable. A qualifying write that completes during this time is discarded.
- R8: If the waiting item is taken in the same clock that a new item arrives, the new item is loaded in that clock and both are delivered in order.
- R9: A bus cycle with no `quad_clk` fall during its phase-low half produces no item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock for all sampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_clk | input | 1 | 1 MHz bus phase clock (high = data half) |
| quad_clk | input | 1 | Bus quadrature clock; its fall in the low half latches the bank bit |
| slow_sel_n | input | 1 | Active-low slow-side select |
| bank_bit | input | 1 | Bank indicator, valid only in a short window (1 = auxiliary) |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr_bus | input | 16 | Bus address |
| data_bus | input | 8 | Bus data |
| snp_valid | output | 1 | Captured write available |
| snp_ready | input | 1 | Sink accepts the item |
| snp_bank | output | 1 | Captured bank bit |
| snp_offset | output | 16 | Write address |
| snp_data | output | 8 | Write data |

## Verification
The two functions that can fall in the same clock are handing a waiting item to the sink and loading a freshly qualified write into the one-entry output. The bench provokes this by holding `snp_ready` low so that one item waits. It then raises `snp_ready` in exactly the clock in which the next write's phase fall reaches the output. The scoreboard must see both items in order, and the output must stay valid for those two back-to-back handshakes. A design that refused to load while full would drop the second item, and the scoreboard would still hold it at the end of the run.

// File: rtl/snp_pkg.sv
package snp_pkg;
  localparam int unsigned SNP_ADDR_W = 16;
  localparam int unsigned SNP_DATA_W = 8;

  typedef struct packed {
    logic                  bank;
    logic [SNP_ADDR_W-1:0] offset;
    logic [SNP_DATA_W-1:0] data;
  } snp_item_t;

  // bus lines as seen after the synchronizer
  typedef struct packed {
    logic                  ph;
    logic                  quad;
    logic                  sel_n;
    logic                  bank;
    logic                  rd_wr_n;
    logic [SNP_ADDR_W-1:0] addr;
    logic [SNP_DATA_W-1:0] data;
  } snp_bus_t;

  localparam int unsigned SNP_BUS_W = $bits(snp_bus_t);
endpackage

// File: rtl/snp_delay.sv
module snp_delay #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_pipe
      logic [W-1:0] stage [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < int'(STAGES); i++) stage[i] <= '0;
        end else begin
          stage[0] <= d;
          for (int i = 1; i < int'(STAGES); i++) stage[i] <= stage[i-1];
        end
      end
      assign q = stage[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/snp_edge.sv
module snp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/snp_bank_latch.sv
module snp_bank_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_lvl,
  input  logic ph_fall,
  input  logic quad_fall,
  input  logic bank_in,
  output logic bank_q,
  output logic bank_ok
);
  // capture only inside the address half; consumed at the phase fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= 1'b0;
      bank_ok <= 1'b0;
    end else if (ph_fall) begin
      bank_ok <= 1'b0;
    end else if (quad_fall && !ph_lvl) begin
      bank_q  <= bank_in;
      bank_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/snp_decode.sv
module snp_decode #(
  parameter int unsigned AW      = 16,
  parameter int unsigned NUM_WIN = 2,
  parameter logic [NUM_WIN*AW-1:0] WIN_LO = {16'h2000, 16'h0400},
  parameter logic [NUM_WIN*AW-1:0] WIN_HI = {16'h3FFF, 16'h07FF}
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [NUM_WIN-1:0] win_hit;
  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam logic [AW-1:0] LO = WIN_LO[w*AW +: AW];
      localparam logic [AW-1:0] HI = WIN_HI[w*AW +: AW];
      assign win_hit[w] = (addr >= LO) && (addr <= HI);
    end
  endgenerate
  assign hit = |win_hit;
endmodule

// File: rtl/snp_out_slot.sv
module snp_out_slot
  import snp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_valid,
  input  snp_item_t in_item,
  input  logic      out_ready,
  output logic      out_valid,
  output snp_item_t out_item
);
  logic load;
  assign load = in_valid && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_item  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_item  <= in_item;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/shadow_snoop.sv
module shadow_snoop
  import snp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NUM_WIN     = 2,
  parameter logic [NUM_WIN*SNP_ADDR_W-1:0] WIN_LO = {16'h2000, 16'h0400},
  parameter logic [NUM_WIN*SNP_ADDR_W-1:0] WIN_HI = {16'h3FFF, 16'h07FF}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  phase_clk,
  input  logic                  quad_clk,
  input  logic                  slow_sel_n,
  input  logic                  bank_bit,
  input  logic                  rd_wr_n,
  input  logic [SNP_ADDR_W-1:0] addr_bus,
  input  logic [SNP_DATA_W-1:0] data_bus,
  output logic                  snp_valid,
  input  logic                  snp_ready,
  output logic                  snp_bank,
  output logic [SNP_ADDR_W-1:0] snp_offset,
  output logic [SNP_DATA_W-1:0] snp_data
);
  snp_bus_t raw, bus;
  assign raw = '{ph: phase_clk, quad: quad_clk, sel_n: slow_sel_n, bank: bank_bit,
                 rd_wr_n: rd_wr_n, addr: addr_bus, data: data_bus};

  // equal delay on every line keeps their relative timing
  snp_delay #(.W(SNP_BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(bus)
  );

  logic ph_rise, ph_fall, quad_rise, quad_fall;
  snp_edge u_ph_edge (.clk(clk), .rst_n(rst_n), .lvl(bus.ph),
                      .rise(ph_rise), .fall(ph_fall));
  snp_edge u_quad_edge (.clk(clk), .rst_n(rst_n), .lvl(bus.quad),
                        .rise(quad_rise), .fall(quad_fall));

  logic bank_q, bank_ok;
  snp_bank_latch u_bank (
    .clk(clk), .rst_n(rst_n), .ph_lvl(bus.ph), .ph_fall(ph_fall),
    .quad_fall(quad_fall), .bank_in(bus.bank), .bank_q(bank_q), .bank_ok(bank_ok)
  );

  // track the data half; the last sample before the fall survives
  logic                  cap_sel_n, cap_rd_wr_n;
  logic [SNP_ADDR_W-1:0] cap_addr;
  logic [SNP_DATA_W-1:0] cap_data;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sel_n   <= 1'b1;
      cap_rd_wr_n <= 1'b1;
      cap_addr    <= '0;
      cap_data    <= '0;
    end else if (bus.ph) begin
      cap_sel_n   <= bus.sel_n;
      cap_rd_wr_n <= bus.rd_wr_n;
      cap_addr    <= bus.addr;
      cap_data    <= bus.data;
    end
  end

  logic win_hit;
  snp_decode #(.AW(SNP_ADDR_W), .NUM_WIN(NUM_WIN), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_dec (
    .addr(cap_addr), .hit(win_hit)
  );

  logic      cand_valid;
  snp_item_t cand_item, slot_item;
  assign cand_valid = ph_fall && bank_ok && !cap_sel_n && !cap_rd_wr_n && win_hit;
  assign cand_item  = '{bank: bank_q, offset: cap_addr, data: cap_data};

  snp_out_slot u_slot (
    .clk(clk), .rst_n(rst_n), .in_valid(cand_valid), .in_item(cand_item),
    .out_ready(snp_ready), .out_valid(snp_valid), .out_item(slot_item)
  );

  assign snp_bank   = slot_item.bank;
  assign snp_offset = slot_item.offset;
  assign snp_data   = slot_item.data;

  logic unused_edges;
  assign unused_edges = ph_rise ^ quad_rise;
endmodule

// File: rtl/snp_checker.sv
module snp_checker #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter logic [2*AW-1:0] WIN_LO = {16'h2000, 16'h0400},
  parameter logic [2*AW-1:0] WIN_HI = {16'h3FFF, 16'h07FF}
) (
  input logic          clk,
  input logic          rst_n,
  input logic          phase_clk,
  input logic          ph_fall,
  input logic          snp_valid,
  input logic          snp_ready,
  input logic          snp_bank,
  input logic [AW-1:0] snp_offset,
  input logic [DW-1:0] snp_data
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_IDLE: assert (!snp_valid); // R1
  end

  AST_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> ((snp_offset >= WIN_LO[AW-1:0] && snp_offset <= WIN_HI[AW-1:0]) ||
                   (snp_offset >= WIN_LO[2*AW-1:AW] && snp_offset <= WIN_HI[2*AW-1:AW]))); // R4

  AST_LOAD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snp_valid) |-> $past(ph_fall)); // R6

  AST_APPEARS_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snp_valid) |-> !phase_clk); // R6

  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_ready && !ph_fall) |=> !snp_valid); // R6

  AST_HOLD_ITEM: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_ready) |=> (snp_valid && $stable(snp_bank) &&
                                   $stable(snp_offset) && $stable(snp_data))); // R7
endmodule

bind shadow_snoop snp_checker #(
  .AW(snp_pkg::SNP_ADDR_W), .DW(snp_pkg::SNP_DATA_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .phase_clk(phase_clk), .ph_fall(ph_fall),
  .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_bank(snp_bank),
  .snp_offset(snp_offset), .snp_data(snp_data)
);

// File: tb/tb_shadow_snoop.sv
`timescale 1ns/100ps
module tb_shadow_snoop;
  localparam int SYNC = 2;
  localparam int CYC  = 64;   // clocks per bus cycle, half low, half high

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_clk = 1'b0, quad_clk = 1'b1, slow_sel_n = 1'b1, bank_bit = 1'b0;
  logic rd_wr_n = 1'b1, snp_ready = 1'b1;
  logic [15:0] addr_bus = '0;
  logic [7:0]  data_bus = '0;
  logic snp_valid, snp_bank;
  logic [15:0] snp_offset;
  logic [7:0]  snp_data;

  always #2 clk = ~clk;

  shadow_snoop #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .phase_clk(phase_clk), .quad_clk(quad_clk),
    .slow_sel_n(slow_sel_n), .bank_bit(bank_bit), .rd_wr_n(rd_wr_n),
    .addr_bus(addr_bus), .data_bus(data_bus), .snp_valid(snp_valid),
    .snp_ready(snp_ready), .snp_bank(snp_bank), .snp_offset(snp_offset),
    .snp_data(snp_data)
  );

  int total = 0, bad = 0, got = 0, run = 0, max_run = 0;
  logic [24:0] expq [$];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [15:0] a);
    return (a >= 16'h0400 && a <= 16'h07FF) || (a >= 16'h2000 && a <= 16'h3FFF);
  endfunction

  // one bus cycle: the address half, then the data half
  task automatic bus_cycle(input logic sel_n, input logic rw, input logic [15:0] a,
                           input logic [7:0] d, input logic bk, input bit do_q,
                           input bit drop, input bit raise);
    if (!sel_n && !rw && do_q && in_win(a) && !drop) expq.push_back({bk, a, d});
    for (int i = 0; i < CYC; i++) begin
      case (i)
        0: begin phase_clk = 0; slow_sel_n = sel_n; rd_wr_n = rw; addr_bus = a;
                 data_bus = ~d; bank_bit = ~bk; quad_clk = 1; end
        2:  if (raise) snp_ready = 1;
        10: bank_bit = bk;
        18: if (do_q) quad_clk = 0;
        24: begin quad_clk = 1; bank_bit = ~bk; end
        32: phase_clk = 1;
        40: data_bus = d;
        48: quad_clk = 0;
        56: quad_clk = 1;
        default: ;
      endcase
      @(negedge clk);
    end
  endtask

  task automatic idle_cycle(input bit raise);
    bus_cycle(1'b1, 1'b1, 16'h0000, 8'h00, 1'b0, 1'b1, 1'b0, raise);
  endtask

  // scoreboard monitor, samples just before each rising edge
  initial begin
    forever begin
      @(negedge clk); #1.5;
      if (rst_n) begin
        if (snp_valid && snp_ready) begin
          got++;
          run++;
          if (run > max_run) max_run = run;
          if (expq.size() == 0) begin
            chk(0, "R3 R4 R9 unexpected item", {7'd0, snp_bank, snp_offset, snp_data}, 0);
          end else begin
            logic [24:0] e;
            e = expq.pop_front();
            chk({snp_bank, snp_offset, snp_data} == e, "R2 R5 item content",
                {7'd0, snp_bank, snp_offset, snp_data}, {7'd0, e});
          end
        end else if (!snp_valid) begin
          run = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(snp_valid == 0, "R1 idle in reset", snp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(snp_valid == 0, "R1 idle after reset", snp_valid, 0);

    // window edges, banks and data (R2 R4 R5)
    bus_cycle(0, 0, 16'h0400, 8'h11, 1, 1, 0, 0);
    bus_cycle(0, 0, 16'h07FF, 8'h22, 0, 1, 0, 0);
    bus_cycle(0, 0, 16'h2000, 8'h33, 1, 1, 0, 0);
    bus_cycle(0, 0, 16'h3FFF, 8'h44, 0, 1, 0, 0);
    // outside the windows (R4)
    bus_cycle(0, 0, 16'h03FF, 8'h55, 1, 1, 0, 0);
    bus_cycle(0, 0, 16'h0800, 8'h56, 1, 1, 0, 0);
    bus_cycle(0, 0, 16'h1FFF, 8'h57, 1, 1, 0, 0);
    bus_cycle(0, 0, 16'h4000, 8'h58, 1, 1, 0, 0);
    // read and fast-side cycles (R3)
    bus_cycle(0, 1, 16'h0500, 8'h66, 1, 1, 0, 0);
    bus_cycle(1, 0, 16'h0500, 8'h67, 1, 1, 0, 0);
    // no quadrature fall in the address half (R9)
    bus_cycle(0, 0, 16'h0600, 8'h77, 1, 0, 0, 0);
    bus_cycle(0, 0, 16'h2ABC, 8'h88, 0, 1, 0, 0);
    idle_cycle(0);
    chk(expq.size() == 0, "R3 R4 R9 queue drained", expq.size(), 0);
    chk(got == 5, "R4 item count", got, 5);
    chk(max_run == 1, "R6 one-clock strobe", max_run, 1);

    // back-pressure: first held, second discarded (R7)
    snp_ready = 0;
    bus_cycle(0, 0, 16'h0410, 8'hA1, 1, 1, 0, 0);
    bus_cycle(0, 0, 16'h0420, 8'hA2, 0, 1, 1, 0);
    idle_cycle(0);
    chk(snp_valid == 1, "R7 item held", snp_valid, 1);
    chk(snp_offset == 16'h0410 && snp_data == 8'hA1 && snp_bank == 1,
        "R7 held item unchanged", {snp_bank, snp_offset, snp_data}, {1'b1, 16'h0410, 8'hA1});
    idle_cycle(0);
    chk(snp_offset == 16'h0410, "R7 still held", snp_offset, 16'h0410);
    snp_ready = 1;
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R7 only first delivered", expq.size(), 0);
    chk(got == 6, "R7 item count", got, 6);

    // accept and load in the same clock (R8)
    snp_ready = 0;
    max_run = 0;
    bus_cycle(0, 0, 16'h2100, 8'hB1, 0, 1, 0, 0);
    bus_cycle(0, 0, 16'h2200, 8'hB2, 1, 1, 0, 0);
    idle_cycle(1);
    idle_cycle(0);
    chk(expq.size() == 0, "R8 both delivered", expq.size(), 0);
    chk(got == 8, "R8 item count", got, 8);
    chk(max_run == 2, "R8 back-to-back handshakes", max_run, 2);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule